// File: doc/BRIEF.md
# Bridge Downstream Forward Decoder

This block sits on the upstream side of a PCI-to-PCI bridge and decides, per transaction, whether the bridge claims an address and passes it to the downstream bus. It takes a 64-bit address, a flag saying whether the access is to I/O or memory space, and the bridge's configuration state: the command-register memory and I/O enables, the I/O and memory base/limit windows, and the bridge-control legacy-display and ISA-alias bits.

An ordinary access is forwarded when it falls inside its window. Two legacy overrides change that. The legacy-display setting claims the display memory hole and the display I/O ports whatever the windows hold. The ISA setting refuses I/O accesses to the upper three quarters of every 1 KB block inside the low 64 KB. The decision is registered and presented with a one-cycle valid strobe one clock after the request strobe.

Top module: `bridge_fwd_decode`

## Requirements
- R1: While rst_ni is low, and after it is released, out_valid_o and fwd_o are 0 until a request is taken.
- R2: out_valid_o is high in exactly the cycles after those in which in_valid_i was high; fwd_o is 0 whenever out_valid_o is 0.
- R3: An I/O access (is_io_i=1) is forwarded when io_en_i=1 and {io_base_i[31:12],000h} <= address <= {io_limit_i[31:12],FFFh}; any set address bit in [63:32] puts it outside the window.
- R4: A memory access (is_io_i=0) is forwarded when mem_en_i=1 and {mem_base_i[31:20],00000h} <= address <= {mem_limit_i[31:20],FFFFFh}; any set address bit in [63:32] puts it outside the window.
- R5: With vga_en_i=1 and mem_en_i=1, a memory access to 000A0000h..000BFFFFh is forwarded whatever the memory window holds.
- R6: With vga_en_i=1 and io_en_i=1, an I/O access whose address bits [63:16] are zero and whose bits [9:0] lie in 3B0h..3BBh or 3C0h..3DFh is forwarded whatever the I/O window holds; bits [15:10] do not matter.
- R7: Legacy-display hits are still gated: a memory hit is refused when mem_en_i=0, an I/O hit when io_en_i=0.
- R8: With isa_en_i=1, an I/O access inside the I/O window with address bits [63:16] zero and bits [9:8] not both zero (offset 100h..3FFh of its 1 KB block) is refused; offsets 000h..0FFh and window hits at or above 64 KB are unaffected.
- R9: A legacy-display I/O hit is forwarded even when R8 would block it.
- R10: With vga_en_i=0, the legacy ranges get no special treatment and only the windows decide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| addr_i | input | 64 | Transaction address |
| is_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| mem_en_i | input | 1 | Command-register memory enable |
| io_en_i | input | 1 | Command-register I/O enable |
| io_base_i | input | 32 | I/O window base (bits 31:12 used) |
| io_limit_i | input | 32 | I/O window limit (bits 31:12 used) |
| mem_base_i | input | 32 | Memory window base (bits 31:20 used) |
| mem_limit_i | input | 32 | Memory window limit (bits 31:20 used) |
| vga_en_i | input | 1 | Legacy-display range enable |
| isa_en_i | input | 1 | ISA alias blocking enable |
| out_valid_o | output | 1 | Decision strobe, one cycle after in_valid_i |
| fwd_o | output | 1 | 1 = claim and forward downstream |

## Verification
The bench aims at the edges of every range: the last byte of each window and the byte past it, the first and last addresses of the display hole and both display port groups, and offsets 0FFh/100h/3FFh/400h around the ISA blocks. A decoder that compared full limits instead of rounding them up would drop the top 4 KB or 1 MB of a window; one that failed to mask bits [15:10] would miss aliased display ports, and one that let ISA blocking win would refuse 3C0h. It also sends port addresses above 64 KB and with upper bits set, which a decoder that ignored bits [63:16] would wrongly claim, and mixes back-to-back requests with random configurations against a behavioural model each clock.

// File: rtl/bfd_pkg.sv
`timescale 1ns/1ps
package bfd_pkg;
  localparam int unsigned ADDR_W   = 64;
  localparam int unsigned WIN_W    = 32;
  localparam int unsigned IO_LSB   = 12;
  localparam int unsigned MEM_LSB  = 20;
  localparam int unsigned BLK_W    = 10;   // 1 KB alias block
  localparam int unsigned LOW_W    = 16;   // first 64 KB of I/O space
  localparam int unsigned ISA_W    = 8;    // low 256 bytes pass
  localparam logic [BLK_W-1:0] VGA_IO_A_LO = 10'h3B0;
  localparam logic [BLK_W-1:0] VGA_IO_A_HI = 10'h3BB;
  localparam logic [BLK_W-1:0] VGA_IO_B_LO = 10'h3C0;
  localparam logic [BLK_W-1:0] VGA_IO_B_HI = 10'h3DF;
  localparam int unsigned VGA_MEM_LSB = 17; // A0000..BFFFF is one 128 KB page
  localparam logic [ADDR_W-VGA_MEM_LSB-1:0] VGA_MEM_PAGE = 'h5;

  typedef struct packed {
    logic io_hit;
    logic mem_hit;
  } legacy_hit_t;
endpackage

// File: rtl/bfd_window.sv
`timescale 1ns/1ps
module bfd_window #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned WIN_W  = 32,
  parameter int unsigned LSB    = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIN_W-1:0]  base_i,
  input  logic [WIN_W-1:0]  limit_i,
  output logic              hit_o
);
  localparam int unsigned CW = WIN_W - LSB;
  logic [CW-1:0] a_pg;
  logic          hi_zero;

  assign a_pg    = addr_i[WIN_W-1:LSB];
  assign hi_zero = (addr_i[ADDR_W-1:WIN_W] == '0);
  // granule compare: base rounds down, limit rounds up
  assign hit_o   = hi_zero && (a_pg >= base_i[WIN_W-1:LSB]) && (a_pg <= limit_i[WIN_W-1:LSB]);
endmodule

// File: rtl/bfd_legacy.sv
`timescale 1ns/1ps
module bfd_legacy
  import bfd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              vga_en_i,
  input  logic              isa_en_i,
  input  logic              io_win_i,
  output legacy_hit_t       hit_o,
  output logic              isa_blk_o
);
  logic [BLK_W-1:0] off;
  logic             low64k;
  logic             in_a, in_b;

  assign off    = addr_i[BLK_W-1:0];
  assign low64k = (addr_i[ADDR_W-1:LOW_W] == '0);
  assign in_a   = (off >= VGA_IO_A_LO) && (off <= VGA_IO_A_HI);
  assign in_b   = (off >= VGA_IO_B_LO) && (off <= VGA_IO_B_HI);

  assign hit_o.io_hit  = vga_en_i && low64k && (in_a || in_b);
  assign hit_o.mem_hit = vga_en_i && (addr_i[ADDR_W-1:VGA_MEM_LSB] == VGA_MEM_PAGE);
  assign isa_blk_o     = isa_en_i && io_win_i && low64k && (off[BLK_W-1:ISA_W] != '0);
endmodule

// File: rtl/bridge_fwd_decode.sv
`timescale 1ns/1ps
module bridge_fwd_decode
  import bfd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [63:0]       addr_i,
  input  logic              is_io_i,
  input  logic              mem_en_i,
  input  logic              io_en_i,
  input  logic [31:0]       io_base_i,
  input  logic [31:0]       io_limit_i,
  input  logic [31:0]       mem_base_i,
  input  logic [31:0]       mem_limit_i,
  input  logic              vga_en_i,
  input  logic              isa_en_i,
  output logic              out_valid_o,
  output logic              fwd_o
);
  logic        io_win, mem_win, isa_blk;
  legacy_hit_t lg;
  logic        io_fwd, mem_fwd, fwd_d;

  bfd_window #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .LSB(IO_LSB)) u_io_win (
    .addr_i(addr_i), .base_i(io_base_i), .limit_i(io_limit_i), .hit_o(io_win)
  );

  bfd_window #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .LSB(MEM_LSB)) u_mem_win (
    .addr_i(addr_i), .base_i(mem_base_i), .limit_i(mem_limit_i), .hit_o(mem_win)
  );

  bfd_legacy u_legacy (
    .addr_i(addr_i), .vga_en_i(vga_en_i), .isa_en_i(isa_en_i),
    .io_win_i(io_win), .hit_o(lg), .isa_blk_o(isa_blk)
  );

  // display hit outranks ISA blocking
  assign io_fwd  = io_en_i  && (lg.io_hit  || (io_win && !isa_blk));
  assign mem_fwd = mem_en_i && (lg.mem_hit || mem_win);
  assign fwd_d   = in_valid_i && (is_io_i ? io_fwd : mem_fwd);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      fwd_o       <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      fwd_o       <= fwd_d;
    end
  end

  p_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i));
  p_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> !fwd_o);
  p_io_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_o && $past(is_io_i)) |-> $past(io_en_i));
  p_mem_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_o && !$past(is_io_i)) |-> $past(mem_en_i));
  p_isa_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && is_io_i && isa_blk && !lg.io_hit) |=> !fwd_o);
  p_vga_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && is_io_i && io_en_i && lg.io_hit) |=> fwd_o);
  p_no_legacy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vga_en_i |-> !(lg.io_hit || lg.mem_hit));
endmodule

// File: tb/bridge_fwd_decode_tb_top.sv
`timescale 1ns/1ps
module bridge_fwd_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] addr = '0;
  logic        is_io = 1'b0;
  logic        mem_en = 1'b0, io_en = 1'b0, vga_en = 1'b0, isa_en = 1'b0;
  logic [31:0] io_base = '0, io_limit = '0, mem_base = '0, mem_limit = '0;
  logic        out_valid, fwd;

  int    n_chk = 0, n_fail = 0;
  bit    mon_on = 1'b0;
  string cur_tag = "R2";
  logic  exp_v, exp_f;
  string exp_tag;

  always #2.5 clk = ~clk;

  bridge_fwd_decode dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .addr_i(addr), .is_io_i(is_io),
    .mem_en_i(mem_en), .io_en_i(io_en), .io_base_i(io_base), .io_limit_i(io_limit),
    .mem_base_i(mem_base), .mem_limit_i(mem_limit), .vga_en_i(vga_en), .isa_en_i(isa_en),
    .out_valid_o(out_valid), .fwd_o(fwd)
  );

  function automatic bit model_fwd();
    longint unsigned a, lo, hi, off;
    bit low, disp, win, blk;
    a = addr;
    off = a % 1024;
    low = (a < 64'h1_0000);
    if (is_io) begin
      lo   = longint'({io_base[31:12], 12'h000});
      hi   = longint'({io_limit[31:12], 12'hFFF});
      win  = (a >= lo) && (a <= hi);
      disp = vga_en && low && ((off >= 'h3B0 && off <= 'h3BB) || (off >= 'h3C0 && off <= 'h3DF));
      blk  = isa_en && win && low && (off >= 256);
      return io_en && (disp || (win && !blk));
    end
    lo   = longint'({mem_base[31:20], 20'h00000});
    hi   = longint'({mem_limit[31:20], 20'hFFFFF});
    win  = (a >= lo) && (a <= hi);
    disp = vga_en && (a >= 'hA0000) && (a <= 'hBFFFF);
    return mem_en && (disp || win);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_v <= 1'b0; exp_f <= 1'b0; exp_tag <= "R1";
    end else begin
      exp_v   <= in_valid;
      exp_f   <= in_valid && model_fwd();
      exp_tag <= in_valid ? cur_tag : "R2";
    end
  end

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      n_chk++;
      if (out_valid !== exp_v || fwd !== exp_f) begin
        n_fail++;
        $display("FAIL %s: valid/fwd = %b/%b expected %b/%b at %0t",
                 exp_tag, out_valid, fwd, exp_v, exp_f, $time);
      end
    end
  end

  task automatic send(input logic [63:0] a, input logic io, input string tag);
    @(negedge clk); #1;
    addr = a; is_io = io; in_valid = 1'b1; cur_tag = tag;
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic cfg(input logic me, input logic ie, input logic ve, input logic se,
                     input logic [31:0] ib, input logic [31:0] il,
                     input logic [31:0] mb, input logic [31:0] ml);
    mem_en = me; io_en = ie; vga_en = ve; isa_en = se;
    io_base = ib; io_limit = il; mem_base = mb; mem_limit = ml;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || fwd !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: valid/fwd in reset = %b/%b expected 0/0", out_valid, fwd);
    end
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (2) @(negedge clk);

    // R3 I/O window 2000h..4FFFh
    cfg(1, 1, 0, 0, 32'h2000, 32'h4000, 32'h4000_0000, 32'h4000_0000);
    send(64'h2000, 1, "R3");
    send(64'h4FFF, 1, "R3");
    send(64'h5000, 1, "R3");
    send(64'h1FFF, 1, "R3");
    send(64'h1_0000_3000, 1, "R3");
    io_en = 0;
    send(64'h3000, 1, "R3");
    // R4 memory window 1000_0000h..100F_FFFFh
    cfg(1, 1, 0, 0, 32'h8000, 32'h8000, 32'h1000_0000, 32'h1000_0000);
    send(64'h1000_0000, 0, "R4");
    send(64'h100F_FFFF, 0, "R4");
    send(64'h1010_0000, 0, "R4");
    send(64'h0FFF_FFFF, 0, "R4");
    send(64'h8_1000_0000, 0, "R4");
    mem_en = 0;
    send(64'h1000_0000, 0, "R4");
    // R5 display memory hole
    cfg(1, 1, 1, 0, 32'h8000, 32'h8000, 32'h1000_0000, 32'h1000_0000);
    send(64'hA0000, 0, "R5");
    send(64'hBFFFF, 0, "R5");
    send(64'hC0000, 0, "R5");
    send(64'h9FFFF, 0, "R5");
    send(64'hA0000, 1, "R5");
    // R6 display ports and aliases
    send(64'h3B0, 1, "R6");
    send(64'h3BB, 1, "R6");
    send(64'h3BC, 1, "R6");
    send(64'h3BF, 1, "R6");
    send(64'h3C0, 1, "R6");
    send(64'h3DF, 1, "R6");
    send(64'h3E0, 1, "R6");
    send(64'h7BB, 1, "R6");
    send(64'hFFDF, 1, "R6");
    send(64'h1_03B0, 1, "R6");
    send(64'h3B0, 0, "R6");
    // R7 enables still gate display hits
    mem_en = 0;
    send(64'hB0000, 0, "R7");
    mem_en = 1; io_en = 0;
    send(64'h3C4, 1, "R7");
    // R8 ISA blocking, window 0..FFFFh
    cfg(1, 1, 0, 1, 32'h0000, 32'hF000, 32'h4000_0000, 32'h4000_0000);
    send(64'h0FF, 1, "R8");
    send(64'h100, 1, "R8");
    send(64'h3FF, 1, "R8");
    send(64'h400, 1, "R8");
    send(64'h4FF, 1, "R8");
    send(64'h500, 1, "R8");
    send(64'hFD00, 1, "R8");
    cfg(1, 1, 0, 1, 32'h1_0000, 32'h1_F000, 32'h4000_0000, 32'h4000_0000);
    send(64'h1_0100, 1, "R8");
    send(64'h1_03FF, 1, "R8");
    cfg(1, 1, 0, 1, 32'h8000, 32'h8000, 32'h4000_0000, 32'h4000_0000);
    send(64'h0FF, 1, "R8");
    // R9 display beats ISA
    cfg(1, 1, 1, 1, 32'h0000, 32'hF000, 32'h4000_0000, 32'h4000_0000);
    send(64'h3C0, 1, "R9");
    send(64'h7B5, 1, "R9");
    send(64'h3A0, 1, "R9");
    send(64'h3BC, 1, "R9");
    // R10 no legacy override when disabled
    cfg(1, 1, 0, 0, 32'h8000, 32'h8000, 32'h1000_0000, 32'h1000_0000);
    send(64'h3B0, 1, "R10");
    send(64'hA0000, 0, "R10");
    cfg(1, 1, 0, 0, 32'h0000, 32'h0000, 32'h0000_0000, 32'h0000_0000);
    send(64'h3B0, 1, "R10");
    send(64'hA0000, 0, "R10");

    // random back-to-back traffic, every clock compared
    @(negedge clk); #1;
    for (int i = 0; i < 600; i++) begin
      if (i % 8 == 0) begin
        mem_en = 1'($urandom); io_en = 1'($urandom);
        vga_en = 1'($urandom); isa_en = 1'($urandom);
        io_base = {16'h0, 4'($urandom), 12'h0} & 32'h0001_F000;
        io_limit = io_base + {16'h0, 4'($urandom), 12'h0};
        mem_base = {$urandom} & 32'h0FF0_0000;
        mem_limit = mem_base + ({$urandom} & 32'h00F0_0000);
      end
      case ($urandom % 4)
        0: addr = {48'h0, 16'($urandom)};
        1: addr = {44'h0, 4'h0, 6'($urandom), 2'h0, 8'($urandom)} | 64'h300;
        2: addr = {32'h0, 32'($urandom)} & 64'h0FFF_FFFF;
        default: addr = {32'($urandom % 2), 12'h0, 20'($urandom)};
      endcase
      is_io = 1'($urandom);
      in_valid = ($urandom % 4) != 0;
      cur_tag = is_io ? "R3/R6/R8" : "R4/R5";
      @(negedge clk); #1;
    end
    in_valid = 0;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule